// File: doc/BRIEF.md
# Alternating-Compare PWM Timer Channel

This block is one channel of a general-purpose counter/timer. It produces a pulse-width-modulated output from a counter and two compare registers that take turns. One register sets the length of the low phase and the other sets the length of the high phase. The counter counts on a prescaled enable strobe. When it reaches the compare value that is currently active, three things happen: the counter goes back to a programmable load value, the internal output level toggles, and the other compare register becomes active. Software picks the values from a period and a duty: high = period × duty / 100 and low = period − high.

Each compare register has a shadow (preload) register behind it. When the low-phase compare matches, the high-phase register is refilled from its shadow. When the high-phase compare matches, the low-phase register is refilled from its shadow. A new period or duty therefore takes effect only at a phase boundary, and the waveform never glitches.

Further controls:
- A force strobe, qualified by the output-enable control, puts the output to a defined low level before the waveform starts.
- A polarity input inverts the pin.
- Four sticky event flags (low-phase compare, high-phase compare, any compare, counter wrap) each have an interrupt enable. Together they form a registered interrupt request.

Top module: `pwm_alt_timer`

## Requirements
- R1: While `rst_n` is low and on the first cycles after it rises, the internal level is 0, `flags` is 0, `irq` is 0 and `pwm_oe` is 0. `pwm_out` then equals `invert`.
- R2: A match means that `cnt_en` is high in a cycle where the counter equals the active compare value. On a match the internal level toggles at that clock edge and the other compare register becomes active. Counting up from load L, a phase with compare value C lasts C − L + 1 enabled counts.
- R3: On a match the counter returns to the load value instead of counting on. While `cnt_en` is low the counter, the level and the active register do not change.
- R4: After a force, counting up (`dir_down`=0) starts with the low-phase register (slot 0) active. Counting down (`dir_down`=1) starts with the high-phase register (slot 1) active. A down phase lasts L − C + 1 enabled counts.
- R5: A match on slot 0 copies preload 1 into compare 1. A match on slot 1 copies preload 0 into compare 0. A direct write to the same compare register in that cycle takes priority over the copy.
- R6: `force_str` together with `oe_ctl` does three things at the next edge: it clears the internal level, reloads the counter and re-selects the starting register. With `oe_ctl` low, `force_str` has no effect. `pwm_oe` is `oe_ctl` delayed by one clock.
- R7: `pwm_out` is the internal level XOR `invert`, with no register in between.
- R8: If the register that is not active holds 0, a match reloads the counter but neither toggles the level nor switches the register. So a duty of 0 or of 100 gives a constant output.
- R9: `flags` bit 0 sets on a slot-0 match, bit 1 on a slot-1 match, bit 2 on any match. Bit 3 sets when the counter wraps, from all ones upward or from zero downward, without a match. Flags stay set until cleared by a 1 in the matching `flag_clr` bit. A set in the same cycle takes priority over the clear.
- R10: `irq` is the OR of `flags & irq_en`, registered for one clock.
- R11: A write with `wr_en` high stores `wr_data` according to `wr_sel`. The codes are: 0 = compare 0 (low phase), 1 = compare 1 (high phase), 2 = preload 0, 3 = preload 1, 4 = load value. Codes 5 to 7 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cnt_en | input | 1 | Prescaled count strobe |
| dir_down | input | 1 | Count direction, 1 = down |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 3 | Register select for a write |
| wr_data | input | W | Write data |
| force_str | input | 1 | Force the output to its low level |
| oe_ctl | input | 1 | Output-enable control |
| invert | input | 1 | Output polarity inversion |
| flag_clr | input | 4 | Write-one-to-clear for the flags |
| irq_en | input | 4 | Per-flag interrupt enables |
| pwm_out | output | 1 | PWM pin |
| pwm_oe | output | 1 | Registered pin output enable |
| flags | output | 4 | Sticky event flags |
| irq | output | 1 | Registered interrupt request |

## Verification
The properties assume sensible programming of the load value. Counting up, it sits at or below both compare values. Counting down, it sits at or above them. Without that, phases run through a counter wrap. The stimulus obeys this: it rewrites the load value and forces the channel before every change of direction, except in one deliberate wrap case. That case places the load just below all ones so that the wrap flag is exercised. The bench model updates its state from the same inputs on every edge, so preload changes made mid-run, gapped count strobes and zero-count phases are all compared cycle by cycle.

// File: rtl/pwm_alt_pkg.sv
package pwm_alt_pkg;
  // write-port register codes
  localparam logic [2:0] SEL_CMP0 = 3'd0;
  localparam logic [2:0] SEL_CMP1 = 3'd1;
  localparam logic [2:0] SEL_PRE0 = 3'd2;
  localparam logic [2:0] SEL_PRE1 = 3'd3;
  localparam logic [2:0] SEL_LOAD = 3'd4;
  // flag bit positions
  localparam int FL_LO  = 0;
  localparam int FL_HI  = 1;
  localparam int FL_ANY = 2;
  localparam int FL_OVF = 3;
  localparam int NFLAG  = 4;
  localparam int NSLOT  = 2;
endpackage

// File: rtl/pwm_alt_cmp_bank.sv
module pwm_alt_cmp_bank
  import pwm_alt_pkg::*;
#(
  parameter int W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [2:0]       wr_sel,
  input  logic [W-1:0]     wr_data,
  input  logic [NSLOT-1:0] reload,
  output logic [W-1:0]     cmp0,
  output logic [W-1:0]     cmp1,
  output logic [W-1:0]     ld_val
);
  logic [W-1:0] cmp_q [NSLOT];
  logic [W-1:0] ld_q, ld_d;

  for (genvar i = 0; i < NSLOT; i++) begin : g_slot
    localparam logic [2:0] CODE_C = 3'(i);
    localparam logic [2:0] CODE_P = 3'(i + 2);
    logic [W-1:0] pre_q, pre_d, cmp_d;

    always_comb begin
      pre_d = pre_q;
      cmp_d = cmp_q[i];
      if (reload[i]) cmp_d = pre_q;
      if (wr_en && wr_sel == CODE_C) cmp_d = wr_data;
      if (wr_en && wr_sel == CODE_P) pre_d = wr_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        pre_q    <= '0;
        cmp_q[i] <= '0;
      end else begin
        pre_q    <= pre_d;
        cmp_q[i] <= cmp_d;
      end
    end
  end

  always_comb begin
    ld_d = ld_q;
    if (wr_en && wr_sel == SEL_LOAD) ld_d = wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ld_q <= '0;
    else        ld_q <= ld_d;
  end

  assign cmp0   = cmp_q[0];
  assign cmp1   = cmp_q[1];
  assign ld_val = ld_q;
endmodule

// File: rtl/pwm_alt_counter.sv
module pwm_alt_counter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cnt_en,
  input  logic         dir_down,
  input  logic         force_go,
  input  logic [W-1:0] cmp0,
  input  logic [W-1:0] cmp1,
  input  logic [W-1:0] ld_val,
  output logic         match_hit,
  output logic         hold,
  output logic         wrap_hit,
  output logic         sel,
  output logic         oflag,
  output logic [W-1:0] cnt
);
  localparam logic [W-1:0] ONE = W'(1);

  logic [W-1:0] active, cnt_d;
  logic         other_zero, sel_d, oflag_d;

  always_comb begin
    active     = sel ? cmp1 : cmp0;
    other_zero = (sel ? cmp0 : cmp1) == '0;
    match_hit  = cnt_en && !force_go && (cnt == active);
    hold       = match_hit && other_zero;
    wrap_hit   = cnt_en && !force_go && !match_hit &&
                 (dir_down ? (cnt == '0) : (cnt == '1));
    cnt_d   = cnt;
    sel_d   = sel;
    oflag_d = oflag;
    if (force_go) begin
      cnt_d   = ld_val;
      sel_d   = dir_down;
      oflag_d = 1'b0;
    end else if (cnt_en) begin
      if (match_hit) begin
        cnt_d = ld_val;
        if (!other_zero) begin
          sel_d   = ~sel;
          oflag_d = ~oflag;
        end
      end else begin
        cnt_d = dir_down ? cnt - ONE : cnt + ONE;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt   <= '0;
      sel   <= 1'b0;
      oflag <= 1'b0;
    end else begin
      cnt   <= cnt_d;
      sel   <= sel_d;
      oflag <= oflag_d;
    end
  end
endmodule

// File: rtl/pwm_alt_flags.sv
module pwm_alt_flags #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_evt,
  input  logic [N-1:0] clr,
  input  logic [N-1:0] en,
  output logic [N-1:0] flags,
  output logic         irq
);
  logic [N-1:0] flags_d;
  logic         irq_d;

  always_comb begin
    flags_d = (flags & ~clr) | set_evt;
    irq_d   = |(flags & en);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags <= '0;
      irq   <= 1'b0;
    end else begin
      flags <= flags_d;
      irq   <= irq_d;
    end
  end
endmodule

// File: rtl/pwm_alt_timer.sv
module pwm_alt_timer
  import pwm_alt_pkg::*;
#(
  parameter int W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cnt_en,
  input  logic             dir_down,
  input  logic             wr_en,
  input  logic [2:0]       wr_sel,
  input  logic [W-1:0]     wr_data,
  input  logic             force_str,
  input  logic             oe_ctl,
  input  logic             invert,
  input  logic [NFLAG-1:0] flag_clr,
  input  logic [NFLAG-1:0] irq_en,
  output logic             pwm_out,
  output logic             pwm_oe,
  output logic [NFLAG-1:0] flags,
  output logic             irq
);
  logic [W-1:0]     cmp0, cmp1, ld_val, cnt;
  logic             match_hit, hold, wrap_hit, sel, oflag, force_go;
  logic [NSLOT-1:0] reload;
  logic [NFLAG-1:0] set_evt;

  assign force_go = force_str && oe_ctl;

  always_comb begin
    reload[0]       = match_hit && sel;
    reload[1]       = match_hit && !sel;
    set_evt         = '0;
    set_evt[FL_LO]  = match_hit && !sel;
    set_evt[FL_HI]  = match_hit && sel;
    set_evt[FL_ANY] = match_hit;
    set_evt[FL_OVF] = wrap_hit;
  end

  pwm_alt_cmp_bank #(.W(W)) u_bank (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .reload(reload), .cmp0(cmp0), .cmp1(cmp1),
    .ld_val(ld_val)
  );

  pwm_alt_counter #(.W(W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .dir_down(dir_down),
    .force_go(force_go), .cmp0(cmp0), .cmp1(cmp1), .ld_val(ld_val),
    .match_hit(match_hit), .hold(hold), .wrap_hit(wrap_hit),
    .sel(sel), .oflag(oflag), .cnt(cnt)
  );

  pwm_alt_flags #(.N(NFLAG)) u_flags (
    .clk(clk), .rst_n(rst_n), .set_evt(set_evt), .clr(flag_clr),
    .en(irq_en), .flags(flags), .irq(irq)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pwm_oe <= 1'b0;
    else        pwm_oe <= oe_ctl;
  end

  assign pwm_out = oflag ^ invert;
endmodule

// File: rtl/pwm_alt_chk.sv
module pwm_alt_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic         cnt_en,
  input logic         force_go,
  input logic         match_hit,
  input logic         hold,
  input logic         sel,
  input logic         oflag,
  input logic [W-1:0] cnt,
  input logic [W-1:0] ld_val,
  input logic [3:0]   flags,
  input logic [3:0]   flag_clr,
  input logic [3:0]   irq_en,
  input logic         irq
);
  AST_TOGGLE_ON_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    match_hit && !hold |=> oflag != $past(oflag)); // R2
  AST_RELOAD_ON_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    match_hit |=> cnt == $past(ld_val)); // R3
  AST_FROZEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !cnt_en && !force_go |=> $stable(cnt) && $stable(oflag) && $stable(sel)); // R3
  AST_FORCE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    force_go |=> !oflag && cnt == $past(ld_val)); // R6
  AST_HOLD_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
    hold |=> $stable(oflag) && $stable(sel)); // R8
  AST_LO_FLAG_SET: assert property (@(posedge clk) disable iff (!rst_n)
    match_hit && !sel |=> flags[0] && flags[2]); // R9
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ($past(flags & ~flag_clr) & ~flags) == 4'b0); // R9
  AST_IRQ_REGISTERED: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> irq == $past(|(flags & irq_en))); // R10
endmodule

bind pwm_alt_timer pwm_alt_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .force_go(force_go),
  .match_hit(match_hit), .hold(hold), .sel(sel), .oflag(oflag),
  .cnt(cnt), .ld_val(ld_val), .flags(flags), .flag_clr(flag_clr),
  .irq_en(irq_en), .irq(irq)
);

// File: tb/tb_pwm_alt_timer.sv
`timescale 1ns/1ps
module tb_pwm_alt_timer;
  localparam int W = 16;
  logic clk, rst_n, cnt_en, dir_down, wr_en, force_str, oe_ctl, invert;
  logic [2:0] wr_sel;
  logic [W-1:0] wr_data;
  logic [3:0] flag_clr, irq_en, flags;
  logic pwm_out, pwm_oe, irq;

  pwm_alt_timer #(.W(W)) dut (
    .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .dir_down(dir_down),
    .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .force_str(force_str), .oe_ctl(oe_ctl), .invert(invert),
    .flag_clr(flag_clr), .irq_en(irq_en), .pwm_out(pwm_out),
    .pwm_oe(pwm_oe), .flags(flags), .irq(irq)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  int total = 0;
  int bad = 0;
  string cur_req = "R1";
  bit done = 0;

  // behavioural reference state
  int m_cnt, m_ld, m_sel, m_lvl, m_oe, m_irq, m_fl;
  int m_cmp[2];
  int m_pre[2];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt = 0; m_ld = 0; m_sel = 0; m_lvl = 0; m_oe = 0; m_irq = 0; m_fl = 0;
      m_cmp[0] = 0; m_cmp[1] = 0; m_pre[0] = 0; m_pre[1] = 0;
    end else begin
      int hit, frc, wrap, setm, oth;
      frc  = (force_str && oe_ctl) ? 1 : 0;
      hit  = (cnt_en && !frc && m_cnt == m_cmp[m_sel]) ? 1 : 0;
      oth  = m_cmp[1 - m_sel];
      wrap = (cnt_en && !frc && !hit &&
              ((dir_down && m_cnt == 0) || (!dir_down && m_cnt == 65535))) ? 1 : 0;
      setm = 0;
      if (hit) setm = (m_sel == 0) ? 5 : 6;
      if (wrap) setm = setm | 8;
      m_irq = ((m_fl & irq_en) != 0) ? 1 : 0;
      m_fl  = (m_fl & ~int'(flag_clr)) | setm;
      m_oe  = oe_ctl;
      if (hit) m_cmp[1 - m_sel] = m_pre[1 - m_sel];
      if (frc) begin
        m_cnt = m_ld; m_sel = dir_down; m_lvl = 0;
      end else if (cnt_en) begin
        if (hit) begin
          m_cnt = m_ld;
          if (oth != 0) begin m_sel = 1 - m_sel; m_lvl = 1 - m_lvl; end
        end else begin
          m_cnt = dir_down ? (m_cnt + 65535) % 65536 : (m_cnt + 1) % 65536;
        end
      end
      if (wr_en) begin
        case (wr_sel)
          3'd0: m_cmp[0] = wr_data;
          3'd1: m_cmp[1] = wr_data;
          3'd2: m_pre[0] = wr_data;
          3'd3: m_pre[1] = wr_data;
          3'd4: m_ld     = wr_data;
          default: ;
        endcase
      end
    end
  end

  task automatic chk(string what, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s act=%0d exp=%0d", cur_req, what, act, exp);
    end
  endtask

  always begin
    @(posedge clk);
    #5;
    if (!done) begin
      chk("pwm_out", pwm_out, m_lvl ^ int'(invert));
      chk("pwm_oe", pwm_oe, m_oe);
      chk("flags", flags, m_fl);
      chk("irq", irq, m_irq);
    end
  end

  task automatic wr(input logic [2:0] s, input int d);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = s; wr_data = W'(d);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic do_force();
    @(negedge clk); force_str = 1'b1;
    @(negedge clk); force_str = 1'b0;
  endtask

  task automatic run(int n, int gap);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      cnt_en = (gap == 0) ? 1'b1 : ((i % gap) == 0);
    end
  endtask

  task automatic clear(input logic [3:0] m);
    @(negedge clk); flag_clr = m;
    @(negedge clk); flag_clr = 4'h0;
  endtask

  initial begin
    #(20 * 150000);
    bad++;
    $display("FAIL watchdog expired act=1 exp=0");
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; cnt_en = 1'b0; dir_down = 1'b0; wr_en = 1'b0; wr_sel = 3'd0;
    wr_data = '0; force_str = 1'b0; oe_ctl = 1'b0; invert = 1'b0;
    flag_clr = 4'h0; irq_en = 4'h0;
    cur_req = "R1";
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("reset flags", flags, 0);
    chk("reset pwm_out", pwm_out, 0);
    // register setup
    cur_req = "R11";
    wr(3'd0, 3); wr(3'd1, 5); wr(3'd2, 3); wr(3'd3, 5); wr(3'd4, 0);
    wr(3'd6, 77);
    cur_req = "R6";
    oe_ctl = 1'b1;
    do_force();
    clear(4'hF);
    cur_req = "R2"; irq_en = 4'b0001;
    run(60, 0);
    cur_req = "R5";
    wr(3'd2, 6); wr(3'd3, 2);
    run(60, 0);
    cur_req = "R10"; irq_en = 4'b0110;
    clear(4'hF);
    run(20, 0);
    cur_req = "R3";
    run(60, 3);
    cnt_en = 1'b0; run(0, 0);
    repeat (10) @(negedge clk);
    cur_req = "R7"; invert = 1'b1;
    run(30, 0);
    invert = 1'b0;
    cur_req = "R8";
    wr(3'd2, 8); wr(3'd3, 0);
    run(50, 0);
    wr(3'd2, 0); wr(3'd3, 8);
    run(50, 0);
    cur_req = "R4";
    cnt_en = 1'b0;
    wr(3'd4, 20); wr(3'd0, 15); wr(3'd1, 12); wr(3'd2, 15); wr(3'd3, 12);
    dir_down = 1'b1;
    do_force();
    run(60, 0);
    cur_req = "R6";
    oe_ctl = 1'b0;
    do_force();
    run(10, 0);
    oe_ctl = 1'b1;
    do_force();
    run(10, 0);
    cur_req = "R9";
    cnt_en = 1'b0; dir_down = 1'b0; irq_en = 4'b1000;
    wr(3'd4, 65520); wr(3'd0, 5); wr(3'd1, 2); wr(3'd2, 5); wr(3'd3, 2);
    do_force();
    clear(4'hF);
    run(60, 0);
    clear(4'b0101);
    run(20, 0);
    cur_req = "R5";
    // direct write in the same cycle as a reload: write wins
    wr(3'd4, 0); wr(3'd0, 4); wr(3'd1, 4); wr(3'd2, 9); wr(3'd3, 9);
    do_force();
    run(3, 0);
    wr(3'd1, 2);
    run(40, 0);
    cnt_en = 1'b0;
    repeat (3) @(negedge clk);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule